// File: doc/BRIEF.md
# Three-Path Programmable Oscillator Divider

This block divides a local-oscillator signal down to the comparison rate of a phase-locked loop. The oscillator arrives as two single-cycle clock enables on the system clock, one for the high band and one for the low band. Each enable pulse is one oscillator edge. Two control bits pick one of three counting paths.

- **High-band path:** a divide-by-two prescaler feeds a dual-modulus (16/17) swallow counter.
- **Mid-band path:** the low-band enable drives the same swallow counter directly.
- **Low-band path:** the low-band enable feeds a plain 12-bit down counter.

Each time a full division completes, the block emits a one-cycle pulse that is meant for the phase comparator.

The divisor word and the path bits are sampled only at a division boundary, so a period is never cut short or stretched by a change in the middle of it. If a divisor is outside the legal range of the selected path, the block uses the nearest legal bound instead. It also sets a flag that stays set until reset.

Top module: `lo_prog_divider`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `div_pulse` and `range_err` are 0.
- R2: With `band_hi`=1 (whatever `swallow_mode` is), the interval between pulses is exactly 2×N assertions of `hi_ce`, where N is the effective divisor. `lo_ce` has no effect.
- R3: With `band_hi`=0 and `swallow_mode`=1, the interval is exactly N assertions of `lo_ce`, for any N from 272 to 65535. N[15:4] sets the count of prescaler cycles and N[3:0] sets how many of them count 17 instead of 16. `hi_ce` has no effect.
- R4: With `band_hi`=0 and `swallow_mode`=0, the interval is exactly N assertions of `lo_ce`, for N from 4 to 4095.
- R5: On the two swallow paths, a `div_word` below 272 is used as 272 and sets `range_err`.
- R6: On the direct path, a `div_word` above 4095 is used as 4095 and one below 4 is used as 4. Either case sets `range_err`.
- R7: `range_err` stays 1 once set, until reset. Configurations that are in range never set it.
- R8: `div_word`, `band_hi` and `swallow_mode` are captured only at reset release and at the end of each division. A period that is already running finishes with the values captured at its start.
- R9: `div_pulse` is high for exactly one cycle. It is high in the cycle after the enable edge that completes the division, and two pulses are never adjacent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_ce | input | 1 | High-band oscillator edge enable |
| lo_ce | input | 1 | Low-band oscillator edge enable |
| div_word | input | 16 | Programmed divisor |
| band_hi | input | 1 | 1 selects the high-band path |
| swallow_mode | input | 1 | With `band_hi`=0: 1 selects the swallow counter, 0 the direct divider |
| div_pulse | output | 1 | One-cycle pulse per completed division |
| range_err | output | 1 | Sticky flag: an out-of-range divisor was clamped |

## Verification
The only visible symptom of a wrong internal state is the spacing of `div_pulse`.

- A prescaler phase error or a swallow count that is off by one moves the interval by one or by 16 edges. This shows up at the very first pulse after the path is armed.
- A configuration that loads before the boundary shows up as a shortened or stretched interval. The bench sees it in the pulse right after the control inputs change.
- A clamp or flag fault is visible at the same boundary where the bad divisor is taken in.

// File: rtl/lo_div_pkg.sv
package lo_div_pkg;
   typedef enum logic [1:0] {
      PATH_DIRECT  = 2'd0,
      PATH_SWALLOW = 2'd1,
      PATH_HI      = 2'd2
   } div_path_e;
endpackage

// File: rtl/lo_div_clamp.sv
module lo_div_clamp #(
   parameter int DIV_W   = 16,
   parameter int PRE_LOG = 4,
   parameter int DIR_W   = 12,
   parameter int DIR_MIN = 4
) (
   input  logic [DIV_W-1:0] word,
   output logic [DIV_W-1:0] sw_val,
   output logic             sw_oor,
   output logic [DIR_W-1:0] dir_val,
   output logic             dir_oor
);
   localparam int SW_MIN_I  = (2 ** PRE_LOG) * ((2 ** PRE_LOG) + 1);
   localparam int DIR_MAX_I = (2 ** DIR_W) - 1;
   localparam logic [DIV_W-1:0] SW_MIN  = DIV_W'(SW_MIN_I);
   localparam logic [DIV_W-1:0] DIR_MAX = DIV_W'(DIR_MAX_I);
   localparam logic [DIV_W-1:0] DMIN    = DIV_W'(DIR_MIN);

   always_comb begin
      sw_oor  = (word < SW_MIN);
      sw_val  = sw_oor ? SW_MIN : word;
      dir_oor = (word > DIR_MAX) || (word < DMIN);
      if (word > DIR_MAX)     dir_val = DIR_W'(DIR_MAX_I);
      else if (word < DMIN)   dir_val = DIR_W'(DIR_MIN);
      else                    dir_val = word[DIR_W-1:0];
   end
endmodule

// File: rtl/lo_div_swallow.sv
module lo_div_swallow #(
   parameter int PRE_LOG = 4,
   parameter int MAIN_W  = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [MAIN_W-1:0]  main_ld,
   input  logic [PRE_LOG-1:0] swal_ld,
   input  logic               ev,
   output logic               term
);
   localparam logic [PRE_LOG:0] END_LONG  = (PRE_LOG+1)'(2 ** PRE_LOG);
   localparam logic [PRE_LOG:0] END_SHORT = END_LONG - 1'b1;

   logic [PRE_LOG:0]   pre_q;
   logic [MAIN_W-1:0]  main_q;
   logic [PRE_LOG-1:0] swal_q;
   logic               pre_end;

   assign pre_end = (pre_q == ((swal_q != '0) ? END_LONG : END_SHORT));
   assign term    = ev && pre_end && (main_q == MAIN_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_q  <= '0;
         main_q <= '0;
         swal_q <= '0;
      end else if (load) begin
         pre_q  <= '0;
         main_q <= main_ld;
         swal_q <= swal_ld;
      end else if (ev) begin
         if (pre_end) begin
            pre_q  <= '0;
            main_q <= main_q - 1'b1;
            if (swal_q != '0) swal_q <= swal_q - 1'b1;
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/lo_div_direct.sv
module lo_div_direct #(
   parameter int DIR_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DIR_W-1:0] cnt_ld,
   input  logic             ev,
   output logic             term
);
   logic [DIR_W-1:0] cnt_q;

   assign term = ev && (cnt_q == DIR_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (load)   cnt_q <= cnt_ld;
      else if (ev)     cnt_q <= cnt_q - 1'b1;
   end
endmodule

// File: rtl/lo_prog_divider.sv
module lo_prog_divider
   import lo_div_pkg::*;
#(
   parameter int DIV_W     = 16,
   parameter int PRE_LOG   = 4,
   parameter int DIR_W     = 12,
   parameter int DIR_MIN   = 4,
   parameter bit HI_PRE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hi_ce,
   input  logic             lo_ce,
   input  logic [DIV_W-1:0] div_word,
   input  logic             band_hi,
   input  logic             swallow_mode,
   output logic             div_pulse,
   output logic             range_err
);
   localparam int MAIN_W = DIV_W - PRE_LOG;

   if (PRE_LOG < 1 || MAIN_W < PRE_LOG + 1) begin : g_bad_split
      $error("lo_prog_divider: divisor split leaves too few main-counter bits");
   end
   if (DIR_W > DIV_W || DIR_MIN < 2) begin : g_bad_direct
      $error("lo_prog_divider: direct divider parameters out of range");
   end

   div_path_e        in_path, cfg_path_q;
   logic [DIV_W-1:0] sw_val;
   logic [DIR_W-1:0] dir_val;
   logic             sw_oor, dir_oor;
   logic             armed_q, load, term;
   logic             hi_ev, ev_sw, ev_dir, sw_term, dir_term;

   assign in_path = band_hi      ? PATH_HI :
                    swallow_mode ? PATH_SWALLOW : PATH_DIRECT;

   lo_div_clamp #(
      .DIV_W(DIV_W), .PRE_LOG(PRE_LOG), .DIR_W(DIR_W), .DIR_MIN(DIR_MIN)
   ) u_clamp (
      .word(div_word), .sw_val(sw_val), .sw_oor(sw_oor),
      .dir_val(dir_val), .dir_oor(dir_oor)
   );

   if (HI_PRE_EN) begin : g_prescale
      logic half_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                                half_q <= 1'b0;
         else if (load)                             half_q <= 1'b0;
         else if (cfg_path_q == PATH_HI && hi_ce)   half_q <= ~half_q;
      end
      assign hi_ev = hi_ce && half_q;
   end else begin : g_no_prescale
      assign hi_ev = hi_ce;
   end

   assign ev_sw  = (cfg_path_q == PATH_HI)      ? hi_ev :
                   (cfg_path_q == PATH_SWALLOW) ? lo_ce : 1'b0;
   assign ev_dir = (cfg_path_q == PATH_DIRECT) && lo_ce;

   lo_div_swallow #(.PRE_LOG(PRE_LOG), .MAIN_W(MAIN_W)) u_swallow (
      .clk(clk), .rst_n(rst_n), .load(load),
      .main_ld(sw_val[DIV_W-1:PRE_LOG]), .swal_ld(sw_val[PRE_LOG-1:0]),
      .ev(ev_sw), .term(sw_term)
   );

   lo_div_direct #(.DIR_W(DIR_W)) u_direct (
      .clk(clk), .rst_n(rst_n), .load(load), .cnt_ld(dir_val),
      .ev(ev_dir), .term(dir_term)
   );

   assign term = armed_q && (sw_term || dir_term);
   assign load = !armed_q || term;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q    <= 1'b0;
         cfg_path_q <= PATH_DIRECT;
         div_pulse  <= 1'b0;
         range_err  <= 1'b0;
      end else begin
         armed_q   <= 1'b1;
         div_pulse <= term;
         if (load) begin
            cfg_path_q <= in_path;
            if ((in_path == PATH_DIRECT) ? dir_oor : sw_oor) range_err <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/lo_div_checker.sv
module lo_div_checker
   import lo_div_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      hi_ce,
   input logic      lo_ce,
   input logic      div_pulse,
   input logic      range_err,
   input logic      load,
   input div_path_e cfg_path
);
   // R9: pulse lasts one cycle
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |=> !div_pulse);
   // R9: a pulse always follows an oscillator edge
   a_r9_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |-> $past(hi_ce || lo_ce));
   // R7: flag is sticky
   a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      range_err |=> range_err);
   // R8: active path changes only at a load
   a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(cfg_path));
   // R1: no pulse while reset is asserted
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> !div_pulse);
endmodule

bind lo_prog_divider lo_div_checker u_chk (
   .clk(clk), .rst_n(rst_n), .hi_ce(hi_ce), .lo_ce(lo_ce),
   .div_pulse(div_pulse), .range_err(range_err),
   .load(load), .cfg_path(cfg_path_q)
);

// File: tb/tb_lo_prog_divider.sv
module tb_lo_prog_divider;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hi_ce = 1'b0, lo_ce = 1'b0;
   logic [15:0] div_word = 16'd4;
   logic        band_hi = 1'b0, swallow_mode = 1'b0;
   logic        div_pulse, range_err;

   int n_chk = 0, n_fail = 0;
   bit act_b, act_m;
   int act_w;
   int cnt = 0, pulses = 0;
   bit exp_err = 1'b0, first_after = 1'b0;

   always #4 clk = ~clk;

   lo_prog_divider dut (
      .clk(clk), .rst_n(rst_n), .hi_ce(hi_ce), .lo_ce(lo_ce),
      .div_word(div_word), .band_hi(band_hi), .swallow_mode(swallow_mode),
      .div_pulse(div_pulse), .range_err(range_err)
   );

   function automatic int eff_div(bit b, bit m, int w);
      if (b || m) return (w < 272) ? 272 : w;
      if (w > 4095) return 4095;
      if (w < 4) return 4;
      return w;
   endfunction

   function automatic int exp_period(bit b, bit m, int w);
      return b ? 2 * eff_div(b, m, w) : eff_div(b, m, w);
   endfunction

   function automatic bit oor(bit b, bit m, int w);
      return eff_div(b, m, w) != w;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic step();
      string tag;
      @(negedge clk);
      if (div_pulse) begin
         if (first_after)                 tag = "R8";
         else if (oor(act_b, act_m, act_w)) tag = (act_b || act_m) ? "R5" : "R6";
         else if (act_b)                  tag = "R2";
         else if (act_m)                  tag = "R3";
         else                             tag = "R4";
         check(cnt == exp_period(act_b, act_m, act_w), tag, cnt,
               exp_period(act_b, act_m, act_w));
         act_b = band_hi; act_m = swallow_mode; act_w = int'(div_word);
         exp_err = exp_err | oor(act_b, act_m, act_w);
         check(range_err == exp_err, "R7", int'(range_err), int'(exp_err));
         cnt = 0;
         pulses++;
         first_after = 1'b0;
      end
      hi_ce = ($urandom % 4) != 0;
      lo_ce = ($urandom % 4) != 0;
      if (act_b ? hi_ce : lo_ce) cnt++;
   endtask

   task automatic apply(bit b, bit m, int w, int n);
      first_after = (b != act_b) || (m != act_m) || (w != act_w);
      band_hi = b; swallow_mode = m; div_word = 16'(w);
      pulses = 0;
      while (pulses < n) step();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd20240607));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(div_pulse == 1'b0, "R1 pulse in reset", int'(div_pulse), 0);
      check(range_err == 1'b0, "R1 flag in reset", int'(range_err), 0);
      rst_n = 1'b1;
      act_b = 1'b0; act_m = 1'b0; act_w = 4;
      @(negedge clk);
      check(div_pulse == 1'b0, "R1 pulse after release", int'(div_pulse), 0);
      check(range_err == 1'b0, "R1 flag after release", int'(range_err), 0);

      apply(0, 0, 4, 2);       // R4 minimum
      apply(0, 0, 4095, 2);    // R4 maximum
      apply(0, 1, 272, 2);     // R3 minimum swallow
      apply(1, 0, 272, 2);     // R2 minimum
      apply(1, 1, 300, 2);     // R2 mode bit ignored
      apply(0, 1, 4111, 2);    // R3 all swallow bits set
      apply(0, 1, 1000, 2);    // R3
      check(range_err == 1'b0, "R7 in-range keeps flag low", int'(range_err), 0);
      apply(0, 1, 100, 2);     // R5 clamp
      apply(1, 0, 17, 2);      // R5 clamp on high band
      apply(0, 0, 2, 2);       // R6 low clamp
      apply(0, 0, 5000, 2);    // R6 high clamp
      for (int i = 0; i < 10; i++) begin
         bit rb, rm;
         int rw;
         rb = ($urandom % 2) != 0;
         rm = ($urandom % 2) != 0;
         rw = (rb || rm) ? 272 + int'($urandom % 700) : 4 + int'($urandom % 900);
         apply(rb, rm, rw, 2);
      end
      check(range_err == 1'b1, "R7 flag still set", int'(range_err), 1);
      summary();
      $finish;
   end
endmodule